// File: doc/BRIEF.md
# Priority-Level Channel Arbiter

This block chooses which of several transfer channels a single transfer engine serves next. Each channel brings an enable, a readiness source (a peripheral request line or a memory-to-memory flag) and a two-bit priority level. A combinational selector looks at the qualified requesters and returns the index of the winner, with a valid flag. The highest level present wins first. Among channels that share that level, the lowest index wins.

A small registered stage sits behind the selector. When the engine is idle and a winner exists, it latches that winner as the grant and marks the engine busy. The grant then stays fixed, whatever the requesters do, until the engine pulses its done input. The cycle after the release is idle, and arbitration resumes from that cycle. A running transfer is never pre-empted.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel takes part in arbitration only when its enable bit is 1 and either its peripheral request bit or its memory-to-memory bit is 1. A disabled channel is never picked, and neither is an enabled channel with both readiness bits at 0.
- R2: The level field of channel i sits in `level_i[2*i+1:2*i]`, with 3 as the top level and 0 as the lowest. The pick is a qualified channel whose level is the maximum level among the qualified channels.
- R3: When several qualified channels share the maximum level, the one with the smallest index is picked.
- R4: When no channel is qualified, `pick_valid_o` is 0 and `pick_idx_o` is 0.
- R5: After reset, `grant_active_o` is 0 and `grant_idx_o` is 0.
- R6: If `grant_active_o` is 0 and `pick_valid_o` is 1 at a rising clock edge, then after that edge `grant_active_o` is 1 and `grant_idx_o` equals the `pick_idx_o` value seen before the edge.
- R7: While `grant_active_o` is 1 and `xfer_done_i` is 0, `grant_active_o` and `grant_idx_o` keep their values across the edge, whatever the request, enable and level inputs do.
- R8: If `grant_active_o` is 1 and `xfer_done_i` is 1 at a rising clock edge, then after that edge `grant_active_o` is 0. No new grant is taken at that same edge.
- R9: While `grant_active_o` is 0, `xfer_done_i` has no effect. With no qualified channel the grant stays inactive, and with a qualified channel the grant is taken exactly as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | NUM_CH | Per-channel enable |
| periph_req_i | input | NUM_CH | Per-channel peripheral request |
| mem2mem_i | input | NUM_CH | Per-channel memory-to-memory mode (always ready) |
| level_i | input | NUM_CH*LVL_W | Packed per-channel priority levels |
| xfer_done_i | input | 1 | One-cycle pulse from the engine ending the current item |
| pick_valid_o | output | 1 | A qualified channel exists (combinational) |
| pick_idx_o | output | IDX_W | Index of the combinational winner |
| grant_active_o | output | 1 | A grant is held (engine busy) |
| grant_idx_o | output | IDX_W | Index of the held grant |

## Verification
The release of a grant by `xfer_done_i` and the presence of a new qualified winner can fall in the same cycle. In that case the release must win and no fresh grant may be taken at that edge. The random stimulus pulses done about one cycle in four while requests, enables and levels change every cycle, so this collision occurs many times. The bench model then expects one idle cycle before the grant is taken on the following edge, with the winner as it stands in that later cycle. A done pulse while idle is also mixed in, and is judged by whether the grant follows only the pick.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int ARB_CH_DEFAULT  = 4;
    localparam int ARB_LVL_DEFAULT = 2;

    typedef enum logic [1:0] {
        PRIO_LOW  = 2'd0,
        PRIO_MED  = 2'd1,
        PRIO_HIGH = 2'd2,
        PRIO_TOP  = 2'd3
    } prio_lvl_e;

endpackage

// File: rtl/dma_arb_qualify.sv
module dma_arb_qualify #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] preq_i,
    input  logic [NUM_CH-1:0] m2m_i,
    output logic [NUM_CH-1:0] ready_o
);

    // A channel is ready when enabled and either source of readiness holds.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ready_o[g] = en_i[g] & (preq_i[g] | m2m_i[g]);
    end

endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select #(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 2,
    localparam int IDX_W   = $clog2(NUM_CH),
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic [NUM_CH-1:0]            req_i,
    input  logic [NUM_CH-1:0][LVL_W-1:0] lvl_i,
    output logic                         valid_o,
    output logic [IDX_W-1:0]             idx_o
);

    // Scan levels from the top down; within a level the first (lowest)
    // index wins. The found flag freezes the first hit.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int lv = NUM_LVL - 1; lv >= 0; lv--) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (!valid_o && req_i[i] && (lvl_i[i] == LVL_W'(lv))) begin
                    valid_o = 1'b1;
                    idx_o   = IDX_W'(i);
                end
            end
        end
    end

    // Checks on the selection result.
    always_comb begin
        if (!valid_o) begin
            assert_empty_zero_R4: assert (idx_o == '0 && req_i == '0);
        end else begin
            assert_pick_requests_R2: assert (req_i[idx_o]);
            for (int i = 0; i < NUM_CH; i++) begin
                if (req_i[i]) begin
                    assert_no_higher_R2: assert (lvl_i[i] <= lvl_i[idx_o]);
                    if (lvl_i[i] == lvl_i[idx_o]) begin
                        assert_low_index_R3: assert (IDX_W'(i) >= idx_o);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pick_valid_i,
    input  logic [IDX_W-1:0] pick_idx_i,
    input  logic             done_i,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (done_i) begin
                st_d.active = 1'b0;
            end
        end else if (pick_valid_i) begin
            st_d.active = 1'b1;
            st_d.idx    = pick_idx_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign idx_o    = st_q.idx;

    assert_take_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_o && pick_valid_i) |=> (active_o && idx_o == $past(pick_idx_i)));

    assert_hold_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !done_i) |=> (active_o && $stable(idx_o)));

    assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && done_i) |=> !active_o);

    assert_idle_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_o && !pick_valid_i) |=> !active_o);

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = ARB_CH_DEFAULT,
    parameter int LVL_W  = ARB_LVL_DEFAULT,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_CH-1:0]       chan_en_i,
    input  logic [NUM_CH-1:0]       periph_req_i,
    input  logic [NUM_CH-1:0]       mem2mem_i,
    input  logic [NUM_CH*LVL_W-1:0] level_i,
    input  logic                    xfer_done_i,
    output logic                    pick_valid_o,
    output logic [IDX_W-1:0]        pick_idx_o,
    output logic                    grant_active_o,
    output logic [IDX_W-1:0]        grant_idx_o
);

    logic [NUM_CH-1:0]            ready;
    logic [NUM_CH-1:0][LVL_W-1:0] lvl_arr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign lvl_arr[g] = level_i[g*LVL_W +: LVL_W];
    end

    dma_arb_qualify #(.NUM_CH(NUM_CH)) u_qualify (
        .en_i    (chan_en_i),
        .preq_i  (periph_req_i),
        .m2m_i   (mem2mem_i),
        .ready_o (ready)
    );

    dma_arb_select #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_select (
        .req_i   (ready),
        .lvl_i   (lvl_arr),
        .valid_o (pick_valid_o),
        .idx_o   (pick_idx_o)
    );

    dma_arb_hold #(.NUM_CH(NUM_CH)) u_hold (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pick_valid_i (pick_valid_o),
        .pick_idx_i   (pick_idx_o),
        .done_i       (xfer_done_i),
        .active_o     (grant_active_o),
        .idx_o        (grant_idx_o)
    );

    // The winner must satisfy the port-level readiness rule.
    always_comb begin
        if (pick_valid_o) begin
            assert_pick_qualified_R1: assert (chan_en_i[pick_idx_o] &&
                (periph_req_i[pick_idx_o] || mem2mem_i[pick_idx_o]));
        end
    end

endmodule

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int LW         = 2;
    localparam int IW         = 2;
    localparam int N_RANDOM   = 3000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   en = '0, preq = '0, m2m = '0;
    logic [NCH*LW-1:0] lvl = '0;
    logic             done = 1'b0;
    logic             pv, ga;
    logic [IW-1:0]    pi, gi;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    bit          exp_act = 1'b0;
    logic [IW-1:0] exp_gidx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_arbiter #(.NUM_CH(NCH), .LVL_W(LW)) u_dma_chan_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en), .periph_req_i(preq),
        .mem2mem_i(m2m), .level_i(lvl), .xfer_done_i(done),
        .pick_valid_o(pv), .pick_idx_o(pi),
        .grant_active_o(ga), .grant_idx_o(gi)
    );

    // Reference pick: find the maximum level among ready channels, then the
    // first channel carrying it. Returns -1 when none is ready.
    function automatic int ref_pick(input logic [NCH-1:0] e, input logic [NCH-1:0] p,
                                    input logic [NCH-1:0] m, input logic [NCH*LW-1:0] l,
                                    output bit tie);
        int best = -1;
        int res = -1;
        int cnt = 0;
        for (int c = 0; c < NCH; c++) begin
            if (e[c] && (p[c] || m[c]) && int'(l[c*LW +: LW]) > best) best = int'(l[c*LW +: LW]);
        end
        for (int c = NCH - 1; c >= 0; c--) begin
            if (e[c] && (p[c] || m[c]) && int'(l[c*LW +: LW]) == best) begin
                res = c;
                cnt++;
            end
        end
        tie = (cnt > 1);
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Check combinational pick against the reference, tagging the rule.
    task automatic check_pick(input string forced_tag);
        bit tie;
        int want = ref_pick(en, preq, m2m, lvl, tie);
        string tag;
        if (forced_tag != "") tag = forced_tag;
        else if (want < 0) tag = "R4";
        else if (tie) tag = "R3";
        else tag = "R2";
        if (want < 0) begin
            check(pv == 1'b0 && pi == '0, tag, {31'd0, pv} * 10 + int'(pi), 0);
        end else begin
            check(pv == 1'b1 && int'(pi) == want, tag, {31'd0, pv} * 10 + int'(pi), 10 + want);
        end
    endtask

    // One cycle: inputs already applied after a negedge; check pick, step the
    // model, cross the edge, check the grant.
    task automatic step(input string pick_tag);
        bit tie;
        int want;
        string gtag;
        #1;
        check_pick(pick_tag);
        want = ref_pick(en, preq, m2m, lvl, tie);
        if (exp_act) begin
            gtag = done ? "R8" : "R7";
            if (done) exp_act = 1'b0;
        end else begin
            gtag = (want >= 0) ? "R6" : (done ? "R9" : "R6");
            if (want >= 0) begin
                exp_act  = 1'b1;
                exp_gidx = IW'(want);
            end
        end
        @(posedge clk);
        #1;
        if (exp_act) check(ga == 1'b1 && gi == exp_gidx, gtag, {31'd0, ga} * 10 + int'(gi), 10 + int'(exp_gidx));
        else         check(ga == 1'b0, gtag, int'(ga), 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R5: reset state
        check(ga == 1'b0 && gi == '0, "R5", {31'd0, ga} * 10 + int'(gi), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: nobody requesting, done while idle has no effect (R9)
        en = '0; preq = '0; m2m = '0; done = 1'b1;
        step("R4");
        done = 1'b0;

        // R1: enabled but neither readiness bit; disabled with readiness
        en = 4'b0101; preq = 4'b1010; m2m = 4'b1010; lvl = 8'hFF;
        step("R1");

        // R1: memory-to-memory alone qualifies channel 2
        en = 4'b0100; preq = '0; m2m = 4'b0100; lvl = 8'h00;
        step("R1");   // takes grant on channel 2 (R6)

        // R7: requests change, no done -> grant held
        en = 4'b1111; preq = 4'b1111; lvl = 8'hC0;
        step("");
        // R8: done with a new winner present -> release only
        done = 1'b1;
        step("");
        done = 1'b0;
        step("");     // R6: top-level channel 3 taken

        // R3: all at equal level -> channel 0
        done = 1'b1; step(""); done = 1'b0;
        lvl = 8'h55; en = 4'b1111; preq = 4'b1111;
        step("R3");
        done = 1'b1; step(""); done = 1'b0;

        // R9: done while idle with a winner -> grant still taken
        en = 4'b0010; preq = 4'b0010; m2m = '0; done = 1'b1;
        step("R9");
        done = 1'b0;

        // Random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            en   = NCH'($urandom);
            if ($urandom_range(3) != 0) en = en | NCH'($urandom);
            preq = NCH'($urandom);
            m2m  = NCH'($urandom) & NCH'($urandom);
            lvl  = (NCH*LW)'($urandom);
            if ($urandom_range(4) == 0) lvl = {NCH{2'($urandom)}};
            done = ($urandom_range(3) == 0);
            step("");
        end
        done = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule